// File: doc/BRIEF.md
# Load/Store and Atomic Memory Unit

This unit executes the memory-access instructions of a 64-bit register machine. It takes one instruction at a time: the 8-bit opcode, the current values of the destination and source registers, a 16-bit signed offset, a 32-bit immediate and the index of the register that receives a loaded value. From these it decodes the kind of access, forms the byte address and drives a single synchronous data-memory port. That port carries a 64-bit word with byte strobes, and it uses a request/ready handshake.

Loads return their value, zero-extended, on a write-back port. Stores write either the immediate or the source register. Atomic add, or, and and xor on 32-bit or 64-bit memory operands run as three phases in order: a read, a compute cycle with no memory traffic, then a write. The `busy` output stays high through every phase. A new instruction is taken only while `busy` is low. An opcode or atomic selector that is not supported raises a one-cycle `fault` and starts no memory access.

Top module: `lsu_rmw_unit`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `fault`, `mem_req` and `wb_valid` are all low.
- R2: Opcode bits 7:5 select the mode: 3 for plain access, 6 for atomic. Bits 4:3 select the size: 0 is 4 bytes, 1 is 2 bytes, 2 is 1 byte, 3 is 8 bytes. Bits 2:0 select the class: 1 is load, 2 is immediate store, 3 is register store.
- R3: The byte address of a load is the source register plus the sign-extended offset. For stores and atomics, the base is the destination register instead.
- R4: A load raises `wb_valid` for exactly one cycle, in the cycle after its read handshake. `wb_data` carries the loaded bytes zero-extended to 64 bits, and `wb_reg` repeats the issued register index.
- R5: An immediate store writes the low bytes of the sign-extended 32-bit immediate, as many bytes as the access size.
- R6: A register store writes the low bytes of the source register, as many bytes as the access size.
- R7: `mem_be` sets one bit for each byte accessed, starting at bit `mem_addr[2:0]`. Data sits on the matching byte lanes of the 64-bit word. Accesses are assumed to be naturally aligned.
- R8: Opcode 0xc3 (4 bytes) and opcode 0xdb (8 bytes) are atomic. The immediate selects the operation: 0x00 add, 0x40 or, 0x50 and, 0xa0 xor. Memory becomes the old value combined with the source register, truncated to the access size. An atomic produces no write-back.
- R9: An atomic runs a read phase, then exactly one cycle with `busy` high and no request, then a write phase. With a ready delay of L cycles on each phase, `busy` stays high for 2(L+1)+1 cycles. A load or store keeps `busy` high for L+1 cycles.
- R10: The following raise `fault` for one cycle after they are taken, with no memory request and no write-back: any other mode or class, a 1-byte or 2-byte atomic, an atomic in the immediate-store class, and any other atomic immediate.
- R11: A request holds its address, strobes, data and direction until `mem_ready`. An instruction presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction present; taken when `busy` is low |
| issue_op | input | 8 | Opcode |
| issue_dst_val | input | 64 | Destination register value (store/atomic base) |
| issue_src_val | input | 64 | Source register value (load base, store data, atomic operand) |
| issue_offset | input | 16 | Signed address offset |
| issue_imm | input | 32 | Immediate: store data or atomic selector |
| issue_rd | input | 4 | Register index to receive a load |
| busy | output | 1 | Instruction in progress |
| fault | output | 1 | One-cycle pulse for an unsupported instruction |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address |
| mem_be | output | 8 | Byte strobes |
| mem_wdata | output | 64 | Lane-aligned write data |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 64 | Read data word |
| wb_valid | output | 1 | Loaded value valid |
| wb_reg | output | 4 | Register index of the loaded value |
| wb_data | output | 64 | Zero-extended loaded value |

## Verification
The hardest case is a second instruction that arrives while an atomic is still in progress. The bench gives the atomic a slow memory and holds a conflicting store on the issue port through every busy cycle. It then removes that store in the cycle where `busy` falls, before any edge could take it. It checks that the store's target bytes are unchanged and that no request appears outside the atomic's own phases. The compute cycle between read and write is visible only as a gap in `mem_req`. The bench confirms it by counting the exact number of busy cycles under more than one ready delay.

// File: rtl/lsu_pkg.sv
// Package: shared encodings and types for the load/store/atomic unit.
// Assumes the 8-bit opcode layout mode[7:5] | size[4:3] | class[2:0].
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_WORD  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_BYTE  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        OPK_LOAD,
        OPK_STORE_IMM,
        OPK_STORE_REG,
        OPK_RMW
    } op_kind_e;

    typedef enum logic [1:0] {
        RMW_ADD,
        RMW_OR,
        RMW_AND,
        RMW_XOR
    } rmw_op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ACCESS,
        PH_CALC,
        PH_WRITE
    } phase_e;

    localparam logic [2:0] MODE_PLAIN = 3'd3;
    localparam logic [2:0] MODE_RMW   = 3'd6;

    localparam logic [2:0] CLS_LOAD   = 3'd1;
    localparam logic [2:0] CLS_STIMM  = 3'd2;
    localparam logic [2:0] CLS_STREG  = 3'd3;

    localparam logic [7:0] SEL_ADD = 8'h00;
    localparam logic [7:0] SEL_OR  = 8'h40;
    localparam logic [7:0] SEL_AND = 8'h50;
    localparam logic [7:0] SEL_XOR = 8'ha0;

    typedef struct packed {
        op_kind_e  kind;
        acc_size_e size;
        rmw_op_e   rmw;
        logic      bad;
    } dec_t;

endpackage

// File: rtl/lsu_opdecode.sv
// Opcode decoder: classifies an instruction and flags unsupported encodings.
// Assumes the immediate is only meaningful as an atomic selector here.
module lsu_opdecode #(
    parameter int IMM_W = 32
) (
    input  logic [7:0]       op,
    input  logic [IMM_W-1:0] imm,
    output lsu_pkg::dec_t    dec
);
    import lsu_pkg::*;

    logic [2:0] mode;
    logic [2:0] cls;
    logic       sel_upper_zero;

    assign mode           = op[7:5];
    assign cls            = op[2:0];
    assign sel_upper_zero = ((imm >> 8) == '0);

    // Map mode/class/size and atomic selector to a kind, or mark illegal.
    always_comb begin
        dec      = '{kind: OPK_LOAD, size: acc_size_e'(op[4:3]), rmw: RMW_ADD, bad: 1'b1};
        if (mode == MODE_PLAIN) begin
            case (cls)
                CLS_LOAD:  begin dec.kind = OPK_LOAD;      dec.bad = 1'b0; end
                CLS_STIMM: begin dec.kind = OPK_STORE_IMM; dec.bad = 1'b0; end
                CLS_STREG: begin dec.kind = OPK_STORE_REG; dec.bad = 1'b0; end
                default:   dec.bad = 1'b1;
            endcase
        end else if (mode == MODE_RMW && cls == CLS_STREG &&
                     (dec.size == SZ_WORD || dec.size == SZ_DWORD) && sel_upper_zero) begin
            dec.kind = OPK_RMW;
            case (imm[7:0])
                SEL_ADD: begin dec.rmw = RMW_ADD; dec.bad = 1'b0; end
                SEL_OR:  begin dec.rmw = RMW_OR;  dec.bad = 1'b0; end
                SEL_AND: begin dec.rmw = RMW_AND; dec.bad = 1'b0; end
                SEL_XOR: begin dec.rmw = RMW_XOR; dec.bad = 1'b0; end
                default: dec.bad = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/lsu_lanes.sv
// Byte-lane steering: strobes, write-data placement and load extraction.
// Assumes naturally aligned accesses inside one DATA_W-bit memory word.
module lsu_lanes #(
    parameter int DATA_W = 64,
    localparam int NBYTES = DATA_W / 8,
    localparam int LANE_W = $clog2(NBYTES)
) (
    input  lsu_pkg::acc_size_e size,
    input  logic [LANE_W-1:0]  lane,
    input  logic [DATA_W-1:0]  store_val,
    input  logic [DATA_W-1:0]  rdata,
    output logic [NBYTES-1:0]  be,
    output logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  load_val
);
    import lsu_pkg::*;

    logic [NBYTES-1:0]  mask;
    logic [DATA_W-1:0]  vmask;
    logic [LANE_W+2:0]  sh;

    // Byte mask of the access size, anchored at lane zero.
    always_comb begin
        mask = '0;
        case (size)
            SZ_BYTE:  mask[0]   = 1'b1;
            SZ_HALF:  mask[1:0] = '1;
            SZ_WORD:  mask[3:0] = '1;
            default:  mask      = '1;
        endcase
    end

    // Expand the byte mask to a bit mask.
    genvar g;
    for (g = 0; g < NBYTES; g++) begin : g_lane
        assign vmask[8*g +: 8] = {8{mask[g]}};
    end

    assign sh       = {lane, 3'b000};
    assign be       = mask << lane;
    assign wdata    = (store_val & vmask) << sh;
    assign load_val = (rdata >> sh) & vmask;

endmodule

// File: rtl/lsu_rmw_alu.sv
// Atomic combine stage: add/or/and/xor with truncation to the access size.
// Assumes the old value arrives zero-extended from the lane extractor.
module lsu_rmw_alu #(
    parameter int DATA_W = 64
) (
    input  lsu_pkg::rmw_op_e   fn,
    input  lsu_pkg::acc_size_e size,
    input  logic [DATA_W-1:0]  old_val,
    input  logic [DATA_W-1:0]  operand,
    output logic [DATA_W-1:0]  result
);
    import lsu_pkg::*;

    // Select the operation, then clear the upper half for 4-byte atomics.
    always_comb begin
        case (fn)
            RMW_ADD: result = old_val + operand;
            RMW_OR:  result = old_val | operand;
            RMW_AND: result = old_val & operand;
            default: result = old_val ^ operand;
        endcase
        if (size != SZ_DWORD) result[DATA_W-1:DATA_W/2] = '0;
    end

endmodule

// File: rtl/lsu_rmw_unit.sv
// Top: one-at-a-time load/store/atomic sequencer on a request/ready memory port.
// Assumes memory holds a request stable until it answers with mem_ready.
module lsu_rmw_unit #(
    parameter int DATA_W = 64,
    parameter int OFF_W  = 16,
    parameter int IMM_W  = 32,
    parameter int RIDX_W = 4,
    localparam int NBYTES = DATA_W / 8,
    localparam int LANE_W = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [7:0]        issue_op,
    input  logic [DATA_W-1:0] issue_dst_val,
    input  logic [DATA_W-1:0] issue_src_val,
    input  logic [OFF_W-1:0]  issue_offset,
    input  logic [IMM_W-1:0]  issue_imm,
    input  logic [RIDX_W-1:0] issue_rd,
    output logic              busy,
    output logic              fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [NBYTES-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wb_valid,
    output logic [RIDX_W-1:0] wb_reg,
    output logic [DATA_W-1:0] wb_data
);
    import lsu_pkg::*;

    dec_t              dec;
    phase_e            phase_q;
    op_kind_e          kind_q;
    acc_size_e         size_q;
    rmw_op_e           rmw_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] old_q;
    logic [RIDX_W-1:0] rd_q;
    logic              accept;
    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] eff_addr;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] rmw_res;

    lsu_opdecode #(.IMM_W(IMM_W)) u_dec (
        .op  (issue_op),
        .imm (issue_imm),
        .dec (dec)
    );

    lsu_lanes #(.DATA_W(DATA_W)) u_lanes (
        .size      (size_q),
        .lane      (addr_q[LANE_W-1:0]),
        .store_val (opnd_q),
        .rdata     (mem_rdata),
        .be        (mem_be),
        .wdata     (mem_wdata),
        .load_val  (load_val)
    );

    lsu_rmw_alu #(.DATA_W(DATA_W)) u_alu (
        .fn      (rmw_q),
        .size    (size_q),
        .old_val (old_q),
        .operand (opnd_q),
        .result  (rmw_res)
    );

    assign accept   = issue_valid && (phase_q == PH_IDLE);
    assign base     = (dec.kind == OPK_LOAD) ? issue_src_val : issue_dst_val;
    assign eff_addr = base + {{(DATA_W-OFF_W){issue_offset[OFF_W-1]}}, issue_offset};
    assign imm_ext  = {{(DATA_W-IMM_W){issue_imm[IMM_W-1]}}, issue_imm};

    assign busy     = (phase_q != PH_IDLE);
    assign mem_req  = (phase_q == PH_ACCESS) || (phase_q == PH_WRITE);
    assign mem_we   = (phase_q == PH_WRITE) ||
                      ((phase_q == PH_ACCESS) &&
                       (kind_q == OPK_STORE_IMM || kind_q == OPK_STORE_REG));
    assign mem_addr = addr_q;

    // Phase sequencer: idle -> access -> (calc -> write) -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            fault   <= 1'b0;
        end else begin
            fault <= accept && dec.bad;
            case (phase_q)
                PH_IDLE:   if (accept && !dec.bad) phase_q <= PH_ACCESS;
                PH_ACCESS: if (mem_ready) phase_q <= (kind_q == OPK_RMW) ? PH_CALC : PH_IDLE;
                PH_CALC:   phase_q <= PH_WRITE;
                default:   if (mem_ready) phase_q <= PH_IDLE;
            endcase
        end
    end

    // Operand registers: latch on accept, capture old value, hold combined result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= OPK_LOAD;
            size_q <= SZ_WORD;
            rmw_q  <= RMW_ADD;
            addr_q <= '0;
            opnd_q <= '0;
            old_q  <= '0;
            rd_q   <= '0;
        end else begin
            if (accept && !dec.bad) begin
                kind_q <= dec.kind;
                size_q <= dec.size;
                rmw_q  <= dec.rmw;
                addr_q <= eff_addr;
                opnd_q <= (dec.kind == OPK_STORE_IMM) ? imm_ext : issue_src_val;
                rd_q   <= issue_rd;
            end
            if (phase_q == PH_ACCESS && mem_ready && kind_q == OPK_RMW) old_q <= load_val;
            if (phase_q == PH_CALC) opnd_q <= rmw_res;
        end
    end

    // Write-back: one-cycle pulse with the extracted load value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_reg   <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= (phase_q == PH_ACCESS) && mem_ready && (kind_q == OPK_LOAD);
            if (phase_q == PH_ACCESS && mem_ready && kind_q == OPK_LOAD) begin
                wb_reg  <= rd_q;
                wb_data <= load_val;
            end
        end
    end

endmodule

// File: rtl/lsu_rmw_unit_chk.sv
// Checker: port-level protocol properties of the load/store/atomic unit.
// Assumes it is bound to lsu_rmw_unit and sees only its ports.
module lsu_rmw_unit_chk #(
    parameter int DATA_W = 64,
    localparam int NBYTES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              fault,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [DATA_W-1:0] mem_addr,
    input logic [NBYTES-1:0] mem_be,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              wb_valid
);

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R11

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!mem_req && !busy && !wb_valid)); // R10

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be) &&
                                     $stable(mem_wdata) && $stable(mem_we))); // R11

    AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(mem_req && mem_ready && !mem_we)); // R4

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                     $countones(mem_be) == 4 || $countones(mem_be) == 8)); // R7

    AST_CALC_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req) |=> (mem_req && mem_we)); // R9

endmodule

bind lsu_rmw_unit lsu_rmw_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .fault     (fault),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .wb_valid  (wb_valid)
);

// File: tb/lsu_rmw_unit_bench.sv
// Bench: behavioural memory and reference model, checked at every falling edge.
module lsu_rmw_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid;
    logic [7:0]  issue_op;
    logic [63:0] issue_dst_val, issue_src_val;
    logic [15:0] issue_offset;
    logic [31:0] issue_imm;
    logic [3:0]  issue_rd;
    logic        busy, fault, mem_req, mem_we, mem_ready;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0]  mem_be;
    logic        wb_valid;
    logic [3:0]  wb_reg;
    logic [63:0] wb_data;

    logic [63:0] dmem    [0:31];
    logic [63:0] ref_mem [0:31];
    int          lat = 0;
    int          wcnt = 0;
    bit          in_op = 1'b0;
    logic [63:0] exp_addr = '0;
    logic [7:0]  exp_be = '0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    lsu_rmw_unit u_lsu_rmw_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_dst_val(issue_dst_val), .issue_src_val(issue_src_val),
        .issue_offset(issue_offset), .issue_imm(issue_imm), .issue_rd(issue_rd),
        .busy(busy), .fault(fault), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
    );

    function automatic logic [63:0] init_word(int i);
        return 64'h8877665544332211 + 64'h0101010101010101 * 64'(i);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Device memory: initialised in reset, written on a write handshake.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) dmem[i] <= init_word(i);
        end else if (mem_req && mem_ready && mem_we) begin
            for (int b = 0; b < 8; b++)
                if (mem_be[b]) dmem[mem_addr[7:3]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
    end
    assign mem_rdata = dmem[mem_addr[7:3]];

    // Ready generator: answer each request after lat waiting cycles.
    initial mem_ready = 1'b0;
    always @(negedge clk) begin
        if (!mem_req) begin
            wcnt = 0; mem_ready = 1'b0;
        end else if (wcnt >= lat) begin
            wcnt = 0; mem_ready = 1'b1;
        end else begin
            wcnt++; mem_ready = 1'b0;
        end
    end

    // Request monitor: address and strobes of every request cycle.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && mem_req) begin
            if (!in_op) chk(1'b0, "R10", "request with no legal op", 64'(mem_req), 64'd0);
            else begin
                chk(mem_addr == exp_addr, "R3", "address", mem_addr, exp_addr);
                chk(mem_be == exp_be, "R7", "strobes", 64'(mem_be), 64'(exp_be));
            end
        end
    end

    function automatic int size_bytes(logic [1:0] s);
        case (s)
            2'd0: return 4;
            2'd1: return 2;
            2'd2: return 1;
            default: return 8;
        endcase
    endfunction

    function automatic logic [63:0] ref_rd(logic [63:0] a, int nb);
        logic [63:0] v = '0;
        for (int i = 0; i < nb; i++) begin
            logic [63:0] x;
            x = a + 64'(i);
            v[8*i +: 8] = ref_mem[x[7:3]][8*x[2:0] +: 8];
        end
        return v;
    endfunction

    task automatic ref_wr(logic [63:0] a, int nb, logic [63:0] v);
        for (int i = 0; i < nb; i++) begin
            logic [63:0] x;
            x = a + 64'(i);
            ref_mem[x[7:3]][8*x[2:0] +: 8] = v[8*i +: 8];
        end
    endtask

    task automatic run_op(string req, logic [7:0] op, logic [63:0] dst, logic [63:0] src,
                          logic [15:0] off, logic [31:0] imm, logic [3:0] rd,
                          int latency, bit shadow);
        logic [2:0]  mode, cls;
        int          nb, exp_busy, cnt;
        bit          is_ld, is_sti, is_str, is_rmw, legal, mem_ok;
        logic [63:0] a, vmask, exp_wb, old, nw, bad_w;
        mode   = op[7:5];
        cls    = op[2:0];
        nb     = size_bytes(op[4:3]);
        is_ld  = (mode == 3'd3 && cls == 3'd1);
        is_sti = (mode == 3'd3 && cls == 3'd2);
        is_str = (mode == 3'd3 && cls == 3'd3);
        is_rmw = (mode == 3'd6 && cls == 3'd3 && (nb == 4 || nb == 8) &&
                  (imm == 32'h0 || imm == 32'h40 || imm == 32'h50 || imm == 32'ha0));
        legal  = is_ld || is_sti || is_str || is_rmw;
        a      = (is_ld ? src : dst) + {{48{off[15]}}, off};
        vmask  = (nb == 8) ? '1 : ((64'd1 << (8*nb)) - 64'd1);
        exp_wb = '0;
        exp_busy = 0;
        if (is_ld) begin
            exp_wb = ref_rd(a, nb); exp_busy = latency + 1;
        end else if (is_sti) begin
            ref_wr(a, nb, {{32{imm[31]}}, imm}); exp_busy = latency + 1;
        end else if (is_str) begin
            ref_wr(a, nb, src); exp_busy = latency + 1;
        end else if (is_rmw) begin
            old = ref_rd(a, nb);
            case (imm)
                32'h0:   nw = old + src;
                32'h40:  nw = old | src;
                32'h50:  nw = old & src;
                default: nw = old ^ src;
            endcase
            ref_wr(a, nb, nw & vmask);
            exp_busy = 2 * (latency + 1) + 1;
        end
        exp_addr = a;
        exp_be   = 8'(((16'd1 << nb) - 16'd1) << a[2:0]);
        lat      = latency;
        in_op    = legal;
        @(negedge clk);
        issue_valid = 1'b1; issue_op = op; issue_dst_val = dst; issue_src_val = src;
        issue_offset = off; issue_imm = imm; issue_rd = rd;
        @(negedge clk);
        issue_valid = 1'b0;
        chk(fault == !legal, legal ? req : "R10", "fault pulse", 64'(fault), 64'(!legal));
        cnt = 0;
        while (busy && cnt < 60) begin
            cnt++;
            if (shadow) begin
                issue_valid = 1'b1; issue_op = 8'h7a; issue_dst_val = 64'ha0;
                issue_offset = 16'h0; issue_imm = 32'h5;
            end
            @(negedge clk);
        end
        issue_valid = 1'b0;
        in_op = 1'b0;
        chk(cnt == exp_busy, is_rmw ? "R9" : req, "busy cycles", 64'(cnt), 64'(exp_busy));
        chk(wb_valid == is_ld, "R4", "write-back strobe", 64'(wb_valid), 64'(is_ld));
        if (is_ld) begin
            chk(wb_data == exp_wb, req, "loaded value", wb_data, exp_wb);
            chk(wb_reg == rd, "R4", "write-back index", 64'(wb_reg), 64'(rd));
        end
        @(negedge clk);
        chk(wb_valid == 1'b0, "R4", "write-back one cycle", 64'(wb_valid), 64'd0);
        mem_ok = 1'b1; bad_w = '0;
        for (int i = 0; i < 32; i++)
            if (dmem[i] !== ref_mem[i]) begin mem_ok = 1'b0; bad_w = 64'(i); end
        chk(mem_ok, req, "memory image (word index)", bad_w, 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R11 watchdog expired: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) ref_mem[i] = init_word(i);
        rst_n = 1'b0; issue_valid = 1'b0; issue_op = '0; issue_dst_val = '0;
        issue_src_val = '0; issue_offset = '0; issue_imm = '0; issue_rd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(!busy && !fault && !mem_req && !wb_valid, "R1", "reset outputs",
            {60'd0, busy, fault, mem_req, wb_valid}, 64'd0);

        // R2 / R4: loads of every size, zero-extended
        run_op("R4", 8'h71, 64'h0,  64'h10, 16'd3, 32'h0, 4'd1, 0, 1'b0);
        run_op("R4", 8'h69, 64'h0,  64'h20, 16'd2, 32'h0, 4'd2, 0, 1'b0);
        run_op("R2", 8'h61, 64'h0,  64'h30, 16'd4, 32'h0, 4'd3, 1, 1'b0);
        run_op("R2", 8'h79, 64'h0,  64'h40, 16'd0, 32'h0, 4'd4, 0, 1'b0);
        // R3: negative offsets and base choice
        run_op("R3", 8'h79, 64'h8,  64'h80, 16'hfff8, 32'h0, 4'd5, 0, 1'b0);
        run_op("R3", 8'h7b, 64'h100, 64'h0123456789abcdef, 16'hffe0, 32'h0, 4'd0, 0, 1'b0);
        // R5: immediate stores, sign-extended
        run_op("R5", 8'h72, 64'h50, 64'h0, 16'd1, 32'h000000ab, 4'd0, 1, 1'b0);
        run_op("R5", 8'h6a, 64'h52, 64'h0, 16'd0, 32'hfffffffe, 4'd0, 1, 1'b0);
        run_op("R5", 8'h62, 64'h58, 64'h0, 16'd4, 32'h12345678, 4'd0, 1, 1'b0);
        run_op("R5", 8'h7a, 64'h60, 64'h0, 16'd0, 32'h80000001, 4'd0, 1, 1'b0);
        // R6: register stores with a slow memory
        run_op("R6", 8'h73, 64'h68, 64'h1122334455667788, 16'd7, 32'h0, 4'd0, 2, 1'b0);
        run_op("R6", 8'h6b, 64'h6a, 64'h99aabbccddeeff01, 16'd0, 32'h0, 4'd0, 2, 1'b0);
        run_op("R6", 8'h63, 64'h6c, 64'h0badf00d76543210, 16'd0, 32'h0, 4'd0, 2, 1'b0);
        run_op("R6", 8'h7b, 64'h70, 64'hdeadbeefcafef00d, 16'd0, 32'h0, 4'd0, 2, 1'b0);
        // R7: read back stored bytes through lanes
        run_op("R7", 8'h71, 64'h0, 64'h50, 16'd1, 32'h0, 4'd6, 0, 1'b0);
        run_op("R7", 8'h69, 64'h0, 64'h52, 16'd0, 32'h0, 4'd7, 0, 1'b0);
        run_op("R7", 8'h79, 64'h0, 64'h60, 16'd0, 32'h0, 4'd8, 1, 1'b0);
        // R8 / R9: atomics of each operation and width
        run_op("R8", 8'hc3, 64'h88, 64'h00000000ffffffff, 16'd0, 32'h00, 4'd0, 0, 1'b0);
        run_op("R8", 8'hdb, 64'h90, 64'h5,                16'd0, 32'h00, 4'd0, 0, 1'b0);
        run_op("R8", 8'hdb, 64'h98, 64'hf0f0f0f000ff00ff, 16'd0, 32'h40, 4'd0, 1, 1'b0);
        run_op("R8", 8'hc3, 64'ha0, 64'h0f0f0f0f,         16'd4, 32'h50, 4'd0, 0, 1'b0);
        run_op("R8", 8'hdb, 64'ha8, 64'hffff0000ffff0000, 16'd0, 32'ha0, 4'd0, 1, 1'b0);
        run_op("R8", 8'hc3, 64'hb0, 64'h8000000180000001, 16'd0, 32'h40, 4'd0, 2, 1'b0);
        // R10: unsupported encodings
        run_op("R10", 8'hd3, 64'h88, 64'h1, 16'd0, 32'h00,  4'd0, 0, 1'b0);
        run_op("R10", 8'hcb, 64'h88, 64'h1, 16'd0, 32'h00,  4'd0, 0, 1'b0);
        run_op("R10", 8'hc2, 64'h88, 64'h1, 16'd0, 32'h00,  4'd0, 0, 1'b0);
        run_op("R10", 8'hc3, 64'h88, 64'h1, 16'd0, 32'h10,  4'd0, 0, 1'b0);
        run_op("R10", 8'hdb, 64'h88, 64'h1, 16'd0, 32'h140, 4'd0, 0, 1'b0);
        run_op("R10", 8'h60, 64'h88, 64'h1, 16'd0, 32'h00,  4'd0, 0, 1'b0);
        run_op("R10", 8'h21, 64'h88, 64'h1, 16'd0, 32'h00,  4'd0, 0, 1'b0);
        // R11: a store held on the issue port during a busy atomic is ignored
        run_op("R11", 8'hdb, 64'hb8, 64'h1, 16'd0, 32'h00, 4'd0, 2, 1'b1);
        run_op("R11", 8'h79, 64'h0, 64'ha0, 16'd0, 32'h0, 4'd9, 0, 1'b0);
        finish_run();
    end

endmodule